// File: doc/BRIEF.md
# Long-Press Power Toggle Controller

This block turns a single normally open momentary push button into a latched on/off power level, in the manner of a desktop power button. While the output is low, pressing the button raises it straight away. While the output is high, only a press held without a break for a configured number of clock cycles lowers it. A press that is too short leaves the output high.

The raw button first passes through a two-flop synchronizer and a debounce filter. The filter accepts a new level only after it has stayed unchanged for a set number of cycles. The clean level drives a small state machine and a saturating hold counter. After each change of state, the button must be seen released before another press is accepted. Because of this, the press that turns the output on can never go on to turn it off. Each change of the output also produces a one-cycle pulse.

Top module: `long_press_toggle`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, `powerOn` and `togglePulse` are 0 after that edge, and the controller waits, off, for a press.
- R2: After the two-flop synchronizer, a level on `btnRaw` is accepted only once it has been stable for DEBOUNCE_CYCLES consecutive cycles. A raw pulse shorter than DEBOUNCE_CYCLES cycles changes nothing.
- R3: While the output is 0, a press (`btnRaw` = 1) held long enough to pass the filter sets `powerOn` to 1. This happens exactly DEBOUNCE_CYCLES + 3 clock edges after the first edge that samples the press, with no hold requirement.
- R4: After turn-on, `powerOn` stays 1 when the button is released.
- R5: While the output is 1 and the button has been released since turn-on, a continuous press turns `powerOn` to 0. This happens exactly DEBOUNCE_CYCLES + HOLD_CYCLES + 3 clock edges after the first edge that samples the press.
- R6: While the output is 1, a press released before the hold threshold leaves `powerOn` at 1 and clears the hold count. Each later press must again be held for the full duration.
- R7: A press that has just changed the output has no further effect however long it is held. The button must be released before another press is accepted.
- R8: After turn-off, `powerOn` stays 0 when the button is released.
- R9: `togglePulse` is 1 for exactly the one cycle in which `powerOn` has just taken a new value, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnRaw | input | 1 | Raw button level, 1 while pressed, asynchronous |
| powerOn | output | 1 | Latched power level |
| togglePulse | output | 1 | One-cycle pulse on each change of `powerOn` |

## Verification
Counted from the first clock edge that samples a new raw level, the clean level is due after DEBOUNCE_CYCLES + 2 edges. Turn-on follows one edge later. Turn-off follows HOLD_CYCLES + 1 edges after the clean level rises. The toggle pulse appears in the same cycle as the new output value. The bench drives the button on falling edges and keeps a behavioural cycle model that is stepped on each rising edge. It compares both outputs against that model at every falling edge. Directed checks sample exactly one cycle before and in the cycle each change is due, so an early or late edge is caught as well as a wrong value.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,  // off, waiting for a press
    ST_ON_REL   = 2'd1,  // just turned on, waiting for release
    ST_ON       = 2'd2,  // on, counting a held press
    ST_OFF_REL  = 2'd3   // just turned off, waiting for release
  } pwr_state_t;

  typedef struct packed {
    logic holdClr;
    logic holdInc;
  } hold_ctl_t;
endpackage

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int HOLD_CYCLES     = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      btnRaw,
  input  hold_ctl_t ctl,
  output logic      btnClean,
  output logic      holdReached
);
  localparam int DB_W   = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [DB_W-1:0]   DB_LAST  = DB_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncQ;
  logic [DB_W-1:0]        dbCnt;
  logic [HOLD_W-1:0]      holdCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= btnRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], btnRaw};
      end
    end
  endgenerate

  assign syncQ = syncChain[SYNC_STAGES-1];

  // Debounce: accept the synchronized level once it differed for DEBOUNCE_CYCLES edges
  always_ff @(posedge clk) begin
    if (rst) begin
      dbCnt    <= '0;
      btnClean <= 1'b0;
    end else if (syncQ == btnClean) begin
      dbCnt <= '0;
    end else if (dbCnt == DB_LAST) begin
      dbCnt    <= '0;
      btnClean <= syncQ;
    end else begin
      dbCnt <= dbCnt + 1'b1;
    end
  end

  // Saturating hold-duration counter
  always_ff @(posedge clk) begin
    if (rst || ctl.holdClr)                  holdCnt <= '0;
    else if (ctl.holdInc && holdCnt != HOLD_MAX) holdCnt <= holdCnt + 1'b1;
  end

  assign holdReached = (holdCnt == HOLD_MAX);

  // R2
  clean_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (btnClean != $past(btnClean)) |-> ($past(syncQ) == btnClean));

  // R2
  clean_after_window_chk: assert property (@(posedge clk) disable iff (rst)
    (btnClean != $past(btnClean)) |-> ($past(dbCnt) == DB_LAST));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= HOLD_MAX);

  // R6
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.holdClr) |-> (holdCnt == '0));
endmodule

// File: rtl/lpt_control.sv
module lpt_control
  import lpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      btnClean,
  input  logic      holdReached,
  output hold_ctl_t ctl,
  output logic      powerOn,
  output logic      togglePulse
);
  pwr_state_t state, nextState;
  logic setOn, setOff;

  always_comb begin
    nextState = state;
    ctl       = '0;
    setOn     = 1'b0;
    setOff    = 1'b0;
    case (state)
      ST_OFF: begin
        if (btnClean) begin
          nextState = ST_ON_REL;
          setOn     = 1'b1;
        end
      end
      ST_ON_REL: begin
        ctl.holdClr = 1'b1;
        if (!btnClean) nextState = ST_ON;
      end
      ST_ON: begin
        if (!btnClean) begin
          ctl.holdClr = 1'b1;
        end else if (holdReached) begin
          nextState   = ST_OFF_REL;
          setOff      = 1'b1;
          ctl.holdClr = 1'b1;
        end else begin
          ctl.holdInc = 1'b1;
        end
      end
      ST_OFF_REL: begin
        if (!btnClean) nextState = ST_OFF;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      powerOn     <= 1'b0;
      togglePulse <= 1'b0;
    end else begin
      state       <= nextState;
      togglePulse <= setOn | setOff;
      if (setOn)       powerOn <= 1'b1;
      else if (setOff) powerOn <= 1'b0;
    end
  end

  // R9
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (powerOn != $past(powerOn)) == togglePulse);

  // R3
  on_needs_press_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(powerOn) |-> $past(btnClean));

  // R5
  off_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(powerOn) |-> ($past(btnClean) && $past(holdReached)));

  // R7
  no_bounce_back_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(powerOn) |=> powerOn);
endmodule

// File: rtl/long_press_toggle.sv
module long_press_toggle
  import lpt_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int HOLD_CYCLES     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic powerOn,
  output logic togglePulse
);
  hold_ctl_t ctl;
  logic      btnClean;
  logic      holdReached;

  lpt_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .HOLD_CYCLES    (HOLD_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .btnRaw     (btnRaw),
    .ctl        (ctl),
    .btnClean   (btnClean),
    .holdReached(holdReached)
  );

  lpt_control u_control (
    .clk        (clk),
    .rst        (rst),
    .btnClean   (btnClean),
    .holdReached(holdReached),
    .ctl        (ctl),
    .powerOn    (powerOn),
    .togglePulse(togglePulse)
  );

  // R1
  reset_off_chk: assert property (@(posedge clk)
    $past(rst) |-> (!powerOn && !togglePulse));
endmodule

// File: tb/long_press_toggle_test.sv
module long_press_toggle_test;
  localparam int DB   = 4;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnRaw = 1'b0;
  logic powerOn, togglePulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  long_press_toggle #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DB), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .btnRaw(btnRaw),
    .powerOn(powerOn), .togglePulse(togglePulse)
  );

  always #2 clk = ~clk;

  // Behavioural reference: raw level history, stable-run length, press timing
  bit syncQ[$];
  bit mClean = 0;
  int mRun = 0;
  int mHeld = 0;
  bit mOn = 0;
  bit mPulse = 0;
  bit mNeedRelease = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      syncQ = '{0, 0};
      mClean = 0; mRun = 0; mHeld = 0;
      mOn = 0; mPulse = 0; mNeedRelease = 0;
    end else begin
      mPulse = 0;
      if (!mClean) begin
        mNeedRelease = 0;
        mHeld = 0;
      end else if (mNeedRelease) begin
        mHeld = 0;
      end else if (!mOn) begin
        mOn = 1; mPulse = 1; mNeedRelease = 1;
      end else if (mHeld >= HOLD) begin
        mOn = 0; mPulse = 1; mNeedRelease = 1; mHeld = 0;
      end else begin
        mHeld++;
      end
      if (syncQ[1] == mClean) mRun = 0;
      else if (mRun == DB - 1) begin mClean = syncQ[1]; mRun = 0; end
      else mRun++;
      syncQ.push_front(btnRaw);
      void'(syncQ.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison against the model (R9 for the pulse)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 R5", powerOn, mOn, "powerOn vs model");
      check("R9", togglePulse, mPulse, "togglePulse vs model");
    end
  end

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; btnRaw = 1'b0;
    waitCycles(3);
    check("R1", powerOn, 1'b0, "powerOn in reset");
    check("R1", togglePulse, 1'b0, "togglePulse in reset");
    rst = 1'b0;
  endtask

  initial begin
    bit [15:0] lfsr;
    doReset();
    waitCycles(5);
    check("R1", powerOn, 1'b0, "powerOn after reset");

    // R2: glitch shorter than the window
    btnRaw = 1'b1; waitCycles(DB - 1); btnRaw = 1'b0;
    waitCycles(20);
    check("R2", powerOn, 1'b0, "short glitch ignored");

    // R3: turn-on timing, R9 pulse
    btnRaw = 1'b1;
    waitCycles(DB + 2);
    check("R3", powerOn, 1'b0, "one cycle before turn-on");
    waitCycles(1);
    check("R3", powerOn, 1'b1, "turn-on edge");
    check("R9", togglePulse, 1'b1, "pulse on turn-on");
    waitCycles(1);
    check("R9", togglePulse, 1'b0, "pulse one cycle only");

    // R7: keep holding well past the threshold
    waitCycles(HOLD + 30);
    check("R7", powerOn, 1'b1, "turn-on press cannot turn off");
    btnRaw = 1'b0; waitCycles(20);
    check("R4", powerOn, 1'b1, "stays on after release");

    // R6: short presses while on
    btnRaw = 1'b1; waitCycles(HOLD - 4); btnRaw = 1'b0; waitCycles(20);
    check("R6", powerOn, 1'b1, "short press while on");
    btnRaw = 1'b1; waitCycles(HOLD - 4); btnRaw = 1'b0; waitCycles(20);
    check("R6", powerOn, 1'b1, "second short press, count cleared");

    // R5: long press, exact turn-off timing
    btnRaw = 1'b1;
    waitCycles(DB + HOLD + 2);
    check("R5", powerOn, 1'b1, "one cycle before turn-off");
    waitCycles(1);
    check("R5", powerOn, 1'b0, "turn-off edge");
    check("R9", togglePulse, 1'b1, "pulse on turn-off");
    waitCycles(30);
    check("R7", powerOn, 1'b0, "turn-off press cannot turn on");
    btnRaw = 1'b0; waitCycles(20);
    check("R8", powerOn, 1'b0, "stays off after release");

    // R2: bouncing contact then settled press
    for (int i = 0; i < 10; i++) begin btnRaw = ~btnRaw; waitCycles(2); end
    btnRaw = 1'b1; waitCycles(DB + 5);
    check("R2", powerOn, 1'b1, "settled after bounce turns on");
    btnRaw = 1'b0; waitCycles(20);

    // R1: reset while on
    doReset();
    check("R1", powerOn, 1'b0, "reset while on");

    // Pseudo-random press lengths, checked against the model each cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      btnRaw = ~btnRaw;
      waitCycles(1 + int'(lfsr[5:0]) % (HOLD + DB + 8));
    end
    btnRaw = 1'b0; waitCycles(30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule